// File: doc/BRIEF.md
# Serial Boot Stream Section Loader

This block sits behind a serial word receiver during a serial boot and turns the stream of 32-bit words into memory writes. The stream carries no header. It is a sequence of sections. Each section begins with a word count. An address word follows the count, and then come exactly that many payload words. Each payload word goes out on a single-cycle memory write port, at the section's address plus its position in the section. A count of zero closes the stream. The block then holds `done_o` high and shows the first section's start address on `entry_o`, so that a sequencer can jump to it.

The loader keeps the two words just below the first program address free for its own stack. A payload word that would land on either of those two addresses is consumed but not written. The loader advances only on `word_valid_i` pulses. It never skips or reorders words, and once it is done it ignores the receiver.

Top module: `boot_stream_loader`

## Requirements
- R1: While reset is active, and at the first clock after reset, `done_o` and `mem_we_o` are 0.
- R2: The first accepted word after reset is a section count, and the next is that section's start address. Neither word produces a memory write.
- R3: The k-th payload word of a section (k counted from 0) is written with `mem_data_o` equal to the word and `mem_addr_o` equal to start address + k.
- R4: A section with a count of one writes exactly one word, and the word that follows is treated as the next section's count.
- R5: An accepted count of zero sets `done_o` on the next clock. `done_o` then stays high until reset, and no further write occurs.
- R6: `entry_o` equals the first section's start address once `done_o` is high. Later sections do not change it.
- R7: A cycle with `word_valid_i` low produces no write and does not advance the stream, whatever `word_i` holds (including zero).
- R8: Consider a payload word whose target address is the first section's start address minus 1 or minus 2. It produces no write, but it still counts as a payload word and still advances the address.
- R9: After `done_o` is high, further valid words produce no write and do not change `entry_o`.
- R10: A payload word accepted at a clock edge shows up as a write (`mem_we_o`=1) in the cycle that follows that edge, and only in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_valid_i | input | 1 | One-cycle strobe marking a received word |
| word_i | input | 32 | Received word |
| mem_we_o | output | 1 | Memory write strobe, one cycle per written word |
| mem_addr_o | output | ADDR_W (24) | Word address of the write |
| mem_data_o | output | 32 | Write data |
| done_o | output | 1 | Stream finished |
| entry_o | output | ADDR_W (24) | First section start address |

## Verification
The bench feeds a stream that contains a count-one section, a section lying entirely in the reserved stack pair, and a section that runs from one word below the pair into it. A loader that skips the guard would write the stack words. A loader that stops the address after a suppressed word would shift the next write. Idle cycles with a zero on the data lines fall in the count slot, where a loader that ignores the strobe would stop early. Words sent after termination and a mid-session reset catch a loader that resumes, or one that overwrites the entry address.

// File: rtl/boot_ld_pkg.sv
package boot_ld_pkg;
  typedef enum logic [1:0] {
    ST_LEN  = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_DONE = 2'd3
  } ld_state_e;
endpackage

// File: rtl/boot_ld_seq.sv
module boot_ld_seq
  import boot_ld_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              take_addr_o,
  output logic              take_data_o,
  output logic              done_o
);
  ld_state_e         st_q, st_d;
  logic [WORD_W-1:0] rem_q, rem_d;

  assign take_addr_o = valid_i && (st_q == ST_ADDR);
  assign take_data_o = valid_i && (st_q == ST_DATA);
  assign done_o      = (st_q == ST_DONE);

  always_comb begin
    st_d  = st_q;
    rem_d = rem_q;
    if (valid_i) begin
      unique case (st_q)
        ST_LEN: begin
          if (word_i == '0) st_d = ST_DONE;
          else begin
            rem_d = word_i;
            st_d  = ST_ADDR;
          end
        end
        ST_ADDR: st_d = ST_DATA;
        ST_DATA: begin
          rem_d = rem_q - 1'b1;
          if (rem_q == WORD_W'(1)) st_d = ST_LEN;
        end
        default: st_d = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_LEN;
      rem_q <= '0;
    end else begin
      st_q  <= st_d;
      rem_q <= rem_d;
    end
  end
endmodule

// File: rtl/boot_ld_addr.sv
module boot_ld_addr #(
  parameter int ADDR_W    = 24,
  parameter int WORD_W    = 32,
  parameter int RSV_WORDS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_addr_i,
  input  logic              take_data_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_data_o,
  output logic [ADDR_W-1:0] entry_o
);
  logic [ADDR_W-1:0] cur_q, entry_q, gap;
  logic              entry_set_q, in_rsv;

  // distance from target up to entry; 1..RSV_WORDS is loader stack
  assign gap    = entry_q - cur_q;
  assign in_rsv = entry_set_q && (gap != '0) && (gap <= ADDR_W'(RSV_WORDS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q       <= '0;
      entry_q     <= '0;
      entry_set_q <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_data_o  <= '0;
    end else begin
      mem_we_o <= 1'b0;
      if (take_addr_i) begin
        cur_q <= word_i[ADDR_W-1:0];
        if (!entry_set_q) begin
          entry_q     <= word_i[ADDR_W-1:0];
          entry_set_q <= 1'b1;
        end
      end else if (take_data_i) begin
        mem_we_o   <= !in_rsv;
        mem_addr_o <= cur_q;
        mem_data_o <= word_i;
        cur_q      <= cur_q + 1'b1;
      end
    end
  end

  assign entry_o = entry_q;
endmodule

// File: rtl/boot_stream_loader.sv
module boot_stream_loader #(
  parameter int ADDR_W    = 24,
  parameter int WORD_W    = 32,
  parameter int RSV_WORDS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_data_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] entry_o
);
  logic take_addr, take_data;

  boot_ld_seq #(.WORD_W(WORD_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (word_valid_i),
    .word_i      (word_i),
    .take_addr_o (take_addr),
    .take_data_o (take_data),
    .done_o      (done_o)
  );

  boot_ld_addr #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .RSV_WORDS(RSV_WORDS)) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_addr_i (take_addr),
    .take_data_i (take_data),
    .word_i      (word_i),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_data_o  (mem_data_o),
    .entry_o     (entry_o)
  );
endmodule

// File: rtl/boot_stream_loader_chk.sv
module boot_stream_loader_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              word_valid_i,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] entry_o
);
  // R5
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  // R5
  no_write_when_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_we_o);

  // R7
  no_idle_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(word_valid_i));

  // R9
  entry_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> $stable(entry_o));

  // R8
  stack_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o != entry_o - 1'b1) && (mem_addr_o != entry_o - 2'd2));
endmodule

bind boot_stream_loader boot_stream_loader_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .word_valid_i (word_valid_i),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .done_o       (done_o),
  .entry_o      (entry_o)
);

// File: tb/sim_boot_stream_loader.sv
`timescale 1ns/1ps
module sim_boot_stream_loader;
  localparam int AW = 24;
  localparam int NV = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          vld = 1'b0;
  logic [31:0]   wrd = '0;
  logic          we, done;
  logic [AW-1:0] addr, entry;
  logic [31:0]   data;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  boot_stream_loader u0 (
    .clk_i(clk), .rst_ni(rst_n), .word_valid_i(vld), .word_i(wrd),
    .mem_we_o(we), .mem_addr_o(addr), .mem_data_o(data),
    .done_o(done), .entry_o(entry)
  );

  // {word, expected write, expected address}
  localparam logic [56:0] VEC [NV] = '{
    {32'h0000_0003, 1'b0, 24'h000000},
    {32'h0000_0100, 1'b0, 24'h000000},
    {32'h0000_00A0, 1'b1, 24'h000100},
    {32'h0000_00A1, 1'b1, 24'h000101},
    {32'h0000_00A2, 1'b1, 24'h000102},
    {32'h0000_0001, 1'b0, 24'h000000},
    {32'h0000_0200, 1'b0, 24'h000000},
    {32'h0000_00B0, 1'b1, 24'h000200},
    {32'h0000_0002, 1'b0, 24'h000000},
    {32'h0000_00FE, 1'b0, 24'h000000},
    {32'h0000_00C0, 1'b0, 24'h000000},
    {32'h0000_00C1, 1'b0, 24'h000000},
    {32'h0000_0002, 1'b0, 24'h000000},
    {32'h0000_00FD, 1'b0, 24'h000000},
    {32'h0000_00D0, 1'b1, 24'h0000FD},
    {32'h0000_00D1, 1'b0, 24'h000000},
    {32'h0000_0000, 1'b0, 24'h000000}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, sample at the following negedge
  task automatic put(input bit v, input logic [31:0] w);
    vld = v;
    wrd = w;
    @(negedge clk);
    vld = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    chk(done == 1'b0, "R1 done in reset", 32'(done), 0);
    chk(we == 1'b0, "R1 we in reset", 32'(we), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0 && we == 1'b0, "R1 after release", {30'd0, done, we}, 0);

    for (int i = 0; i < NV; i++) begin
      put(1'b1, VEC[i][56:25]);
      chk(we == VEC[i][24], $sformatf("R2 R3 R8 R10 row %0d we", i), 32'(we), 32'(VEC[i][24]));
      if (VEC[i][24]) begin
        chk(addr == VEC[i][23:0], $sformatf("R3 row %0d addr", i), 32'(addr), 32'(VEC[i][23:0]));
        chk(data == VEC[i][56:25], $sformatf("R3 row %0d data", i), data, VEC[i][56:25]);
      end
      if (i % 3 == 1) begin
        put(1'b0, 32'h0);
        chk(we == 1'b0, $sformatf("R7 idle after row %0d", i), 32'(we), 0);
      end
    end
    chk(done == 1'b1, "R5 done after zero count", 32'(done), 1);
    chk(entry == 24'h000100, "R6 entry", 32'(entry), 32'h100);

    // words after termination
    put(1'b1, 32'h3);
    put(1'b1, 32'h300);
    put(1'b1, 32'h55);
    chk(we == 1'b0, "R9 no write after done", 32'(we), 0);
    chk(done == 1'b1, "R5 done held", 32'(done), 1);
    chk(entry == 24'h000100, "R9 entry kept", 32'(entry), 32'h100);

    // mid-session reset, then count-one stream
    rst_n = 1'b0;
    @(negedge clk);
    chk(done == 1'b0 && we == 1'b0, "R1 re-reset", {30'd0, done, we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    put(1'b1, 32'h1);
    put(1'b1, 32'h40);
    put(1'b1, 32'h77);
    chk(we == 1'b1 && addr == 24'h40 && data == 32'h77, "R4 single word", {addr, data[7:0]}, {24'h40, 8'h77});
    put(1'b0, 32'h0);
    chk(we == 1'b0, "R10 one-cycle strobe", 32'(we), 0);
    put(1'b1, 32'h0);
    chk(done == 1'b1, "R4 next word is count", 32'(done), 1);
    chk(entry == 24'h40, "R6 entry after reset", 32'(entry), 32'h40);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule